// File: doc/BRIEF.md
# Branch Direction and Target Predictor

This block sits in the fetch stage and predicts control flow for the current fetch address. It keeps two independent structures. The first is a direction table of 2-bit saturating counters, indexed by low address bits and holding no tags, so distinct branches whose low bits agree share one counter. The second is a direct-mapped target buffer whose entries carry a tag, a stored target and a valid bit. Only the target buffer decides whether the fetch address is a branch. When it hits, the counter picks between the stored target and the sequential address.

Lookup is combinational from `fetch_pc`. Training happens at the clock edge when `upd_valid` is high. It uses the resolved branch address, the real outcome and the real target. Every resolution trains the counter it indexes. Only taken resolutions write the target buffer.

Each counter is a four-state machine. The states are `CNT_STRONG_NT` (0), `CNT_WEAK_NT` (1), `CNT_WEAK_T` (2) and `CNT_STRONG_T` (3). A taken outcome moves one state up and a not-taken outcome moves one state down. The moves are STRONG_NT→WEAK_NT→WEAK_T→STRONG_T upward and the reverse downward. `CNT_STRONG_T` stays put on taken, and `CNT_STRONG_NT` stays put on not-taken.

Top module: `bp_fetch_predictor`

## Requirements
- R1: After reset every target-buffer entry is invalid, so any `fetch_pc` gives `pred_is_branch`=0, `pred_taken`=0 and `pred_next_pc`=`fetch_pc`+4. Every counter resets to `CNT_WEAK_NT`, so one taken resolution is enough to predict taken.
- R2: A counter moves up one state on a taken resolution and down one state on a not-taken resolution. It holds at `CNT_STRONG_T` (3) and at `CNT_STRONG_NT` (0). States 2 and 3 predict taken, and states 0 and 1 predict not-taken.
- R3: The direction table has 64 entries indexed by PC bits [7:2] and stores no tag. Two addresses that differ only above bit 7 train and read the same counter.
- R4: The target buffer has 16 direct-mapped entries indexed by PC bits [5:2], and the tag is PC bits [31:6]. A lookup hits only when the entry is valid and the whole tag equals the fetch address tag.
- R5: A taken resolution writes the entry at its index with its tag, its target and a set valid bit, replacing whatever entry was there before.
- R6: A not-taken resolution writes nothing into the target buffer. A missing entry stays missing, and an existing entry is kept.
- R7: `pred_taken` is 1 only when the target buffer hits and the counter predicts taken, and `pred_next_pc` is then the stored target. In every other case `pred_next_pc` is `fetch_pc`+4, wrapping modulo 2^32.
- R8: When an update and a lookup touch the same entries in one cycle, the lookup returns the contents from before the update.
- R9: The counter is trained on every resolution, whether or not the target buffer holds an entry for that address.
- R10: When `upd_valid` is 0, the `upd_*` inputs change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | Address being fetched |
| pred_is_branch | output | 1 | Target buffer hit: the address is a known branch |
| pred_taken | output | 1 | Hit and the counter predicts taken |
| pred_next_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A branch resolved this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch |
| upd_target | input | 32 | Real target of the resolved branch |

## Verification
Two situations are hard to reach from the ports. The first is driving a counter against each of its saturation limits while its target entry is live, so that the limit shows at the outputs. The stimulus pins one address and trains it through runs of taken and then not-taken outcomes. After each step it probes that address, and a counter that wrapped would flip the prediction in the following cycle. The second is aliasing. A second address that shares both indexes but has a different tag is used in three ways: to train the shared counter without a hit, to show that a not-taken update leaves the first entry alone, and to evict that entry with a taken update. Same-cycle update and lookup pairs check that the lookup sees the old contents.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        CNT_STRONG_NT = 2'd0,
        CNT_WEAK_NT   = 2'd1,
        CNT_WEAK_T    = 2'd2,
        CNT_STRONG_T  = 2'd3
    } ctr_state_e;

    // One step of the saturating direction counter.
    function automatic ctr_state_e ctr_next(input ctr_state_e cur, input logic taken);
        ctr_state_e nxt;
        unique case (cur)
            CNT_STRONG_NT: nxt = taken ? CNT_WEAK_NT  : CNT_STRONG_NT;
            CNT_WEAK_NT:   nxt = taken ? CNT_WEAK_T   : CNT_STRONG_NT;
            CNT_WEAK_T:    nxt = taken ? CNT_STRONG_T : CNT_WEAK_NT;
            CNT_STRONG_T:  nxt = taken ? CNT_STRONG_T : CNT_WEAK_T;
            default:       nxt = CNT_WEAK_NT;
        endcase
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input ctr_state_e cur);
        return (cur == CNT_WEAK_T) || (cur == CNT_STRONG_T);
    endfunction

endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table
    import bp_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    ctr_state_e ctr_q [ENTRIES];

    // State register: every counter resets to weakly not-taken.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                ctr_q[e] <= CNT_WEAK_NT;
            end
        end else if (wr_en) begin
            ctr_q[wr_idx] <= ctr_next(ctr_q[wr_idx], wr_taken);
        end
    end

    // Output: read before any same-cycle write lands.
    always_comb begin
        rd_taken = ctr_says_taken(ctr_q[rd_idx]);
    end

endmodule

// File: rtl/bp_target_buf.sv
module bp_target_buf #(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 26,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [PC_W-1:0]  rd_target,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_target
);

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [PC_W-1:0]    tgt_q [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_target;
        end
    end

    always_comb begin
        rd_hit    = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        rd_target = tgt_q[rd_idx];
    end

endmodule

// File: rtl/bp_fetch_predictor.sv
module bp_fetch_predictor #(
    parameter int PC_W        = 32,
    parameter int OFF_W       = 2,
    parameter int DIR_ENTRIES = 64,
    parameter int TGT_ENTRIES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_is_branch,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_next_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);

    localparam int DIR_IDX_W = $clog2(DIR_ENTRIES);
    localparam int TGT_IDX_W = $clog2(TGT_ENTRIES);
    localparam int TAG_LSB   = OFF_W + TGT_IDX_W;
    localparam int TAG_W     = PC_W - TAG_LSB;
    localparam int STEP      = 1 << OFF_W;

    logic                 dir_taken;
    logic                 tb_hit;
    logic [PC_W-1:0]      tb_target;
    logic [PC_W-1:0]      seq_pc;
    logic                 unused_upd_lsb;

    assign unused_upd_lsb = ^upd_pc[OFF_W-1:0];

    bp_dir_table #(
        .ENTRIES (DIR_ENTRIES)
    ) dir_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (fetch_pc[OFF_W +: DIR_IDX_W]),
        .rd_taken (dir_taken),
        .wr_en    (upd_valid),
        .wr_idx   (upd_pc[OFF_W +: DIR_IDX_W]),
        .wr_taken (upd_taken)
    );

    bp_target_buf #(
        .PC_W    (PC_W),
        .ENTRIES (TGT_ENTRIES),
        .TAG_W   (TAG_W)
    ) tgt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (fetch_pc[OFF_W +: TGT_IDX_W]),
        .rd_tag    (fetch_pc[PC_W-1:TAG_LSB]),
        .rd_hit    (tb_hit),
        .rd_target (tb_target),
        .wr_en     (upd_valid && upd_taken),
        .wr_idx    (upd_pc[OFF_W +: TGT_IDX_W]),
        .wr_tag    (upd_pc[PC_W-1:TAG_LSB]),
        .wr_target (upd_target)
    );

    always_comb begin
        seq_pc         = fetch_pc + PC_W'(STEP);
        pred_is_branch = tb_hit;
        pred_taken     = tb_hit && dir_taken;
        pred_next_pc   = pred_taken ? tb_target : seq_pc;
    end

endmodule

// File: rtl/bp_fetch_predictor_chk.sv
module bp_fetch_predictor_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] fetch_pc,
    input logic            pred_is_branch,
    input logic            pred_taken,
    input logic [PC_W-1:0] pred_next_pc,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic            upd_taken,
    input logic [PC_W-1:0] upd_target
);

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !pred_is_branch); // R1

    AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> pred_is_branch); // R7

    AST_NOT_TAKEN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> pred_next_pc == fetch_pc + PC_W'(4)); // R7

    AST_TAKEN_ALLOCATES: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) |=>
            (fetch_pc != $past(upd_pc)) ||
            (pred_is_branch && (!pred_taken || pred_next_pc == $past(upd_target)))); // R5

    AST_NT_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && !pred_is_branch && fetch_pc == upd_pc) |=>
            (fetch_pc != $past(fetch_pc)) || !pred_is_branch); // R6

    AST_CTR_STAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && pred_taken && fetch_pc == upd_pc) |=>
            (fetch_pc != $past(fetch_pc)) || pred_taken); // R2

    AST_CTR_STAYS_NT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && pred_is_branch && !pred_taken && fetch_pc == upd_pc) |=>
            (fetch_pc != $past(fetch_pc)) || !pred_taken); // R2

endmodule

bind bp_fetch_predictor bp_fetch_predictor_chk #(.PC_W(PC_W)) chk_i (.*);

// File: tb/bp_fetch_predictor_tb_top.sv
module bp_fetch_predictor_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        br;
        logic        tk;
        logic [31:0] nx;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_is_branch;
    logic        pred_taken;
    logic [31:0] pred_next_pc;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bp_fetch_predictor dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .fetch_pc       (fetch_pc),
        .pred_is_branch (pred_is_branch),
        .pred_taken     (pred_taken),
        .pred_next_pc   (pred_next_pc),
        .upd_valid      (upd_valid),
        .upd_pc         (upd_pc),
        .upd_taken      (upd_taken),
        .upd_target     (upd_target)
    );

    // Driver: one cycle of probe plus optional training; expectation is pre-update state.
    task automatic cyc(input logic [31:0] pc, input logic uv, input logic [31:0] upc,
                       input logic ut, input logic [31:0] utgt,
                       input logic eb, input logic et, input logic [31:0] en, input string req);
        exp_t x;
        @(posedge clk);
        #1;
        fetch_pc   = pc;
        upd_valid  = uv;
        upd_pc     = upc;
        upd_taken  = ut;
        upd_target = utgt;
        x.br = eb; x.tk = et; x.nx = en; x.req = req;
        sb_q.push_back(x);
    endtask

    // Monitor: compare at the falling edge, away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t x;
                x = sb_q.pop_front();
                n_checks++;
                if (pred_is_branch !== x.br || pred_taken !== x.tk || pred_next_pc !== x.nx) begin
                    n_errors++;
                    $display("FAIL %s: got br=%0b tk=%0b nx=%08h, expected br=%0b tk=%0b nx=%08h",
                             x.req, pred_is_branch, pred_taken, pred_next_pc, x.br, x.tk, x.nx);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    localparam logic [31:0] PA = 32'h0000_0100; // dir idx 0, buf idx 0, tag 4
    localparam logic [31:0] PB = 32'h0000_0200; // same indexes, tag 8
    localparam logic [31:0] PD = 32'h0000_003C; // dir idx 15, buf idx 15
    localparam logic [31:0] PE = 32'h8000_0100; // tag differs from PA in top bit only
    localparam logic [31:0] PF = 32'hFFFF_FFFC;
    localparam logic [31:0] TA = 32'h0000_0800;
    localparam logic [31:0] TB = 32'h0000_0900;
    localparam logic [31:0] TD = 32'h0000_1000;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: empty after reset
        cyc(PA, 0, 0, 0, 0,   0, 0, PA + 4, "R1 reset miss");
        // R8: update and lookup together see old contents
        cyc(PA, 1, PA, 1, TA, 0, 0, PA + 4, "R8 old contents");
        // R1/R5: weak-NT plus one taken predicts taken; entry allocated
        cyc(PA, 1, PA, 1, TA, 1, 1, TA, "R5 alloc, R1 weak start");
        cyc(PA, 1, PA, 1, TA, 1, 1, TA, "R2 count up");
        cyc(PA, 1, PA, 0, 0,  1, 1, TA, "R2 saturate at 3");
        cyc(PA, 1, PA, 0, 0,  1, 1, TA, "R2 down to weak taken");
        cyc(PA, 1, PA, 0, 0,  1, 0, PA + 4, "R6 entry kept, R2 weak NT");
        cyc(PA, 1, PA, 0, 0,  1, 0, PA + 4, "R2 strong NT");
        cyc(PA, 1, PA, 1, TA, 1, 0, PA + 4, "R2 saturate at 0");
        cyc(PA, 1, PA, 1, TA, 1, 0, PA + 4, "R2 up to weak NT");
        cyc(PA, 0, 0, 0, 0,   1, 1, TA, "R2 back to taken");
        // R4: same index, other tag
        cyc(PB, 0, 0, 0, 0,   0, 0, PB + 4, "R4 tag mismatch");
        // R3/R9: train shared counter through aliasing miss address
        cyc(PA, 1, PB, 0, 0,  1, 1, TA, "R9 pre-alias");
        cyc(PA, 0, 0, 0, 0,   1, 0, PA + 4, "R3 R9 R6 shared counter, no alloc");
        // R5: replacement
        cyc(PA, 1, PB, 1, TB, 1, 0, PA + 4, "R5 pre-replace");
        cyc(PA, 0, 0, 0, 0,   0, 0, PA + 4, "R5 evicted");
        cyc(PB, 0, 0, 0, 0,   1, 1, TB, "R5 new occupant");
        // other index
        cyc(PD, 1, PD, 1, TD, 0, 0, PD + 4, "R4 other index miss");
        cyc(PD, 0, 0, 0, 0,   1, 1, TD, "R5 other index hit");
        cyc(PB, 0, 0, 0, 0,   1, 1, TB, "R3 independent entries");
        // R4: full tag compare
        cyc(PE, 0, 0, 0, 0,   0, 0, PE + 4, "R4 top tag bit");
        // R7: sequential wrap
        cyc(PF, 0, 0, 0, 0,   0, 0, 32'h0, "R7 wrap");
        // R10: inactive update ignored
        cyc(PB, 0, PB, 0, 0,  1, 1, TB, "R10 idle update");
        cyc(PB, 0, PB, 0, 0,  1, 1, TB, "R10 still taken");
        cyc(PB, 0, 0, 0, 0,   1, 1, TB, "R10 unchanged");
        @(posedge clk);
        @(negedge clk);
        #1;
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule